// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit condition and control flag store of an 8-bit processor core. Each cycle a 4-bit operation code chooses what happens to the flags. The register can hold its contents or take a whole byte from the data bus. It can capture a subset of the arithmetic result flags from the ALU, or set or clear one control flag. Beside the visible byte it keeps a hidden carry/borrow bit. This bit is used only for effective-address arithmetic and leaves the core on a separate output.

The break flag follows a break-instruction indicator supplied by the sequencer. An external overflow request forces the overflow flag high. The request arrives already synchronised and edge-detected. A stall input freezes everything, including the hidden carry. Bit 5 of the flag byte is tied high.

Top module: `status_flag_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) makes `flags_out` equal 8'h24 (I and the fixed bit set, all others clear) and `aux_c_out` equal 0.
- R2: `flags_out[5]` is 1 in every cycle after reset, including after a bus load of 8'h00.
- R3: While `stall` is high at a clock edge, `flags_out` and `aux_c_out` keep their values whatever `func`, `sov_req`, `brk_in`, `bus_in` and the ALU flags carry.
- R4: `func` = 1 loads N, V, D, I, Z, C from `bus_in` bits 7, 6, 3, 2, 1, 0 into the same positions.
- R5: On every clock edge without reset or stall, bit 4 (B) takes the value of `brk_in`.
- R6: `func` = 2 loads N (bit 7) and Z (bit 1) from `alu_n`/`alu_z`. `func` = 3 also loads C (bit 0) from `alu_c`. `func` = 4 also loads V (bit 6) from `alu_v`. Flags these codes do not name are left unchanged.
- R7: `func` 5/6 set/clear C (bit 0). `func` 7/8 set/clear I (bit 2). `func` 9/10 set/clear D (bit 3). `func` 11 clears V (bit 6). No other visible flag changes.
- R8: `sov_req` high at an edge without reset or stall sets V (bit 6) to 1. This takes priority over every `func`, including 1 and 11.
- R9: `func` = 12 copies `aux_c_in` into `aux_c_out` and changes no visible flag other than B. Every other code leaves `aux_c_out` unchanged.
- R10: `func` values 0, 13, 14 and 15 leave N, V, D, I, Z, C unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Wait request; freezes all state |
| func | input | 4 | Flag operation code |
| bus_in | input | 8 | Data bus byte for full loads |
| alu_n | input | 1 | ALU negative result |
| alu_v | input | 1 | ALU overflow result |
| alu_z | input | 1 | ALU zero result |
| alu_c | input | 1 | ALU carry/borrow result |
| aux_c_in | input | 1 | Address-arithmetic carry from the ALU |
| brk_in | input | 1 | Break-instruction indicator |
| sov_req | input | 1 | External set-overflow request |
| flags_out | output | 8 | Flag byte N V 1 B D I Z C |
| aux_c_out | output | 1 | Hidden address-arithmetic carry |

## Verification
Every bit is a register feeding the port directly. A wrong decode or a wrong priority therefore shows on `flags_out` or `aux_c_out` in the cycle right after the offending edge. Stale state also persists, so later cycles can reveal it. Random operation codes mixed with stalls, overflow requests and occasional resets are compared each cycle against a model built from the requirements. Directed cases cover a zero-byte load, an overflow request colliding with clear-overflow, and a request that arrives while stalled.

// File: rtl/flag_reg_pkg.sv
package flag_reg_pkg;

    localparam int FLAG_W = 8;
    localparam int FUNC_W = 4;

    localparam int POS_C   = 0;
    localparam int POS_Z   = 1;
    localparam int POS_I   = 2;
    localparam int POS_D   = 3;
    localparam int POS_B   = 4;
    localparam int POS_ONE = 5;
    localparam int POS_V   = 6;
    localparam int POS_N   = 7;

    localparam logic [FLAG_W-1:0] ONE_MASK    = FLAG_W'(1) << POS_ONE;
    localparam logic [FLAG_W-1:0] RESET_FLAGS = ONE_MASK | (FLAG_W'(1) << POS_I);

    typedef enum logic [FUNC_W-1:0] {
        FN_HOLD = 4'd0,
        FN_LOAD = 4'd1,
        FN_NZ   = 4'd2,
        FN_NZC  = 4'd3,
        FN_NVZC = 4'd4,
        FN_SEC  = 4'd5,
        FN_CLC  = 4'd6,
        FN_SEI  = 4'd7,
        FN_CLI  = 4'd8,
        FN_SED  = 4'd9,
        FN_CLD  = 4'd10,
        FN_CLV  = 4'd11,
        FN_AUX  = 4'd12
    } flag_fn_e;

    typedef enum logic [2:0] {
        SRC_KEEP,
        SRC_BUS,
        SRC_ALU,
        SRC_ONE,
        SRC_ZERO
    } flag_src_e;

    typedef struct packed {
        flag_src_e [FLAG_W-1:0] sel;
        logic                   aux_we;
    } flag_ctl_t;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

    function automatic logic [FLAG_W-1:0] alu_to_vec(alu_flags_t a);
        logic [FLAG_W-1:0] r;
        r        = '0;
        r[POS_N] = a.n;
        r[POS_V] = a.v;
        r[POS_Z] = a.z;
        r[POS_C] = a.c;
        return r;
    endfunction

endpackage

// File: rtl/flag_fn_decode.sv
module flag_fn_decode
    import flag_reg_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output flag_ctl_t         ctl
);

    always_comb begin
        for (int i = 0; i < FLAG_W; i++) begin
            ctl.sel[i] = SRC_KEEP;
        end
        ctl.aux_we = 1'b0;
        case (func)
            FN_LOAD: begin
                ctl.sel[POS_N] = SRC_BUS;
                ctl.sel[POS_V] = SRC_BUS;
                ctl.sel[POS_D] = SRC_BUS;
                ctl.sel[POS_I] = SRC_BUS;
                ctl.sel[POS_Z] = SRC_BUS;
                ctl.sel[POS_C] = SRC_BUS;
            end
            FN_NZ: begin
                ctl.sel[POS_N] = SRC_ALU;
                ctl.sel[POS_Z] = SRC_ALU;
            end
            FN_NZC: begin
                ctl.sel[POS_N] = SRC_ALU;
                ctl.sel[POS_Z] = SRC_ALU;
                ctl.sel[POS_C] = SRC_ALU;
            end
            FN_NVZC: begin
                ctl.sel[POS_N] = SRC_ALU;
                ctl.sel[POS_V] = SRC_ALU;
                ctl.sel[POS_Z] = SRC_ALU;
                ctl.sel[POS_C] = SRC_ALU;
            end
            FN_SEC:  ctl.sel[POS_C] = SRC_ONE;
            FN_CLC:  ctl.sel[POS_C] = SRC_ZERO;
            FN_SEI:  ctl.sel[POS_I] = SRC_ONE;
            FN_CLI:  ctl.sel[POS_I] = SRC_ZERO;
            FN_SED:  ctl.sel[POS_D] = SRC_ONE;
            FN_CLD:  ctl.sel[POS_D] = SRC_ZERO;
            FN_CLV:  ctl.sel[POS_V] = SRC_ZERO;
            FN_AUX:  ctl.aux_we     = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/flag_next.sv
module flag_next
    import flag_reg_pkg::*;
(
    input  flag_ctl_t         ctl,
    input  logic [FLAG_W-1:0] cur,
    input  logic [FLAG_W-1:0] bus,
    input  logic [FLAG_W-1:0] alu_vec,
    input  logic              brk,
    input  logic              sov,
    input  logic              aux_cur,
    input  logic              aux_in,
    output logic [FLAG_W-1:0] nxt,
    output logic              aux_nxt
);

    logic [FLAG_W-1:0] sel_val;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
        if (g == POS_ONE) begin : g_fixed
            assign sel_val[g] = 1'b1;
        end else if (g == POS_B) begin : g_brk
            assign sel_val[g] = brk;
        end else begin : g_mux
            always_comb begin
                case (ctl.sel[g])
                    SRC_BUS:  sel_val[g] = bus[g];
                    SRC_ALU:  sel_val[g] = alu_vec[g];
                    SRC_ONE:  sel_val[g] = 1'b1;
                    SRC_ZERO: sel_val[g] = 1'b0;
                    default:  sel_val[g] = cur[g];
                endcase
            end
        end
    end

    always_comb begin
        nxt = sel_val;
        if (sov) begin
            nxt[POS_V] = 1'b1;
        end
    end

    assign aux_nxt = ctl.aux_we ? aux_in : aux_cur;

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import flag_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic [FUNC_W-1:0] func,
    input  logic [7:0]        bus_in,
    input  logic              alu_n,
    input  logic              alu_v,
    input  logic              alu_z,
    input  logic              alu_c,
    input  logic              aux_c_in,
    input  logic              brk_in,
    input  logic              sov_req,
    output logic [7:0]        flags_out,
    output logic              aux_c_out
);

    flag_ctl_t         ctl;
    alu_flags_t        alu_f;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;
    logic              aux_q;
    logic              aux_d;

    assign alu_f = '{n: alu_n, v: alu_v, z: alu_z, c: alu_c};

    flag_fn_decode u_dec (
        .func (func),
        .ctl  (ctl)
    );

    flag_next u_next (
        .ctl     (ctl),
        .cur     (flags_q),
        .bus     (bus_in),
        .alu_vec (alu_to_vec(alu_f)),
        .brk     (brk_in),
        .sov     (sov_req),
        .aux_cur (aux_q),
        .aux_in  (aux_c_in),
        .nxt     (flags_d),
        .aux_nxt (aux_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= RESET_FLAGS;
            aux_q   <= 1'b0;
        end else if (!stall) begin
            flags_q <= flags_d;
            aux_q   <= aux_d;
        end
    end

    assign flags_out = flags_q;
    assign aux_c_out = aux_q;

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (flags_out == RESET_FLAGS) && !aux_c_out);

    assert_fixed_bit_R2: assert property (@(posedge clk) disable iff (rst)
        flags_q[POS_ONE]);

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(flags_out) && $stable(aux_c_out));

    assert_bus_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall && !sov_req && func == FN_LOAD) |=>
        ({flags_out[7:6], flags_out[3:0]} == {$past(bus_in[7:6]), $past(bus_in[3:0])}));

    assert_brk_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !stall |=> flags_out[POS_B] == $past(brk_in));

    assert_sov_force_R8: assert property (@(posedge clk) disable iff (rst)
        (!stall && sov_req) |=> flags_out[POS_V]);

    assert_aux_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (func != FN_AUX) |=> $stable(aux_c_out));

endmodule

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;
    localparam int SEED       = 1234;

    logic       clk = 1'b0;
    logic       rst;
    logic       stall;
    logic [3:0] func;
    logic [7:0] bus_in;
    logic       alu_n, alu_v, alu_z, alu_c;
    logic       aux_c_in;
    logic       brk_in;
    logic       sov_req;
    logic [7:0] flags_out;
    logic       aux_c_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_f;
    logic       exp_a;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_flag_reg u_status_flag_reg (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .func      (func),
        .bus_in    (bus_in),
        .alu_n     (alu_n),
        .alu_v     (alu_v),
        .alu_z     (alu_z),
        .alu_c     (alu_c),
        .aux_c_in  (aux_c_in),
        .brk_in    (brk_in),
        .sov_req   (sov_req),
        .flags_out (flags_out),
        .aux_c_out (aux_c_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(input logic r, input logic s, input logic sv,
                                      input logic [3:0] f);
        if (r) return "R1";
        if (s) return "R3";
        if (sv) return "R8";
        if (f == 4'd1) return "R4";
        if (f >= 4'd2 && f <= 4'd4) return "R6";
        if (f >= 4'd5 && f <= 4'd11) return "R7";
        if (f == 4'd12) return "R9";
        return "R10";
    endfunction

    // Model from the requirements; applies one clock edge.
    task automatic model(input logic r, input logic s, input logic [3:0] f,
                         input logic [7:0] b, input logic n, input logic v,
                         input logic z, input logic c, input logic ax,
                         input logic bk, input logic sv);
        if (r) begin
            exp_f = 8'h24;
            exp_a = 1'b0;
        end else if (!s) begin
            case (f)
                4'd1: begin
                    exp_f[7:6] = b[7:6];
                    exp_f[3:0] = b[3:0];
                end
                4'd2: begin exp_f[7] = n; exp_f[1] = z; end
                4'd3: begin exp_f[7] = n; exp_f[1] = z; exp_f[0] = c; end
                4'd4: begin exp_f[7] = n; exp_f[6] = v; exp_f[1] = z; exp_f[0] = c; end
                4'd5: exp_f[0] = 1'b1;
                4'd6: exp_f[0] = 1'b0;
                4'd7: exp_f[2] = 1'b1;
                4'd8: exp_f[2] = 1'b0;
                4'd9: exp_f[3] = 1'b1;
                4'd10: exp_f[3] = 1'b0;
                4'd11: exp_f[6] = 1'b0;
                4'd12: exp_a = ax;
                default: ;
            endcase
            exp_f[4] = bk;
            exp_f[5] = 1'b1;
            if (sv) exp_f[6] = 1'b1;
        end
    endtask

    // Called at a falling edge: drives, lets one rising edge pass, checks.
    task automatic step(input logic r, input logic s, input logic [3:0] f,
                        input logic [7:0] b, input logic [3:0] nvzc,
                        input logic ax, input logic bk, input logic sv);
        string t;
        rst = r; stall = s; func = f; bus_in = b;
        alu_n = nvzc[3]; alu_v = nvzc[2]; alu_z = nvzc[1]; alu_c = nvzc[0];
        aux_c_in = ax; brk_in = bk; sov_req = sv;
        model(r, s, f, b, nvzc[3], nvzc[2], nvzc[1], nvzc[0], ax, bk, sv);
        t = tag_for(r, s, sv, f);
        @(negedge clk);
        chk(t, flags_out, exp_f);
        chk("R2", {7'd0, flags_out[5]}, {7'd0, 1'b1});
        chk((r || s) ? t : "R5", {7'd0, flags_out[4]}, {7'd0, exp_f[4]});
        chk((f == 4'd12 || r || s) ? t : "R9", {7'd0, aux_c_out}, {7'd0, exp_a});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(SEED);
        rst = 1'b1; stall = 1'b0; func = 4'd0; bus_in = 8'h00;
        alu_n = 1'b0; alu_v = 1'b0; alu_z = 1'b0; alu_c = 1'b0;
        aux_c_in = 1'b0; brk_in = 1'b0; sov_req = 1'b0;
        @(negedge clk);

        // R1: reset value
        step(1'b1, 1'b0, 4'd0, 8'hFF, 4'hF, 1'b1, 1'b1, 1'b1);
        // R2/R4: load zero byte, fixed bit stays set
        step(1'b0, 1'b0, 4'd1, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0);
        chk("R2", flags_out, 8'h20);
        // R4: load all ones
        step(1'b0, 1'b0, 4'd1, 8'hFF, 4'h0, 1'b0, 1'b0, 1'b0);
        // R8: overflow request beats clear-overflow
        step(1'b0, 1'b0, 4'd11, 8'h00, 4'h0, 1'b0, 1'b0, 1'b1);
        chk("R8", {7'd0, flags_out[6]}, 8'd1);
        // R7: clear-overflow alone
        step(1'b0, 1'b0, 4'd11, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0);
        // R3: request while stalled is ignored
        step(1'b0, 1'b1, 4'd12, 8'h00, 4'hF, 1'b1, 1'b1, 1'b1);
        chk("R3", {7'd0, flags_out[6]}, 8'd0);
        // R9: aux carry set then held by another code
        step(1'b0, 1'b0, 4'd12, 8'h00, 4'h0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'd4, 8'h00, 4'hA, 1'b0, 1'b0, 1'b0);
        // R8: overflow request during a bus load with bit 6 clear
        step(1'b0, 1'b0, 4'd1, 8'h00, 4'h0, 1'b0, 1'b1, 1'b1);
        // R10: unused codes
        step(1'b0, 1'b0, 4'd15, 8'h00, 4'hF, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic r, s, sv;
            r  = ($urandom % 300) == 0;
            s  = ($urandom % 6) == 0;
            sv = ($urandom % 7) == 0;
            step(r, s, 4'($urandom % 16), 8'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), sv);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule